// File: doc/BRIEF.md
# Strobe Gate Drift Tracking Controller

This block keeps the read-strobe enable window of a DDR read path centred on the strobe that the memory returns, while voltage and temperature drift move that strobe over time. Every time the memory controller reports a finished refresh, the block raises busy, takes the command interface and asks a read engine for one read burst. The engine answers with an acknowledge and a one-bit verdict telling whether the enable window fell before the last rising strobe edge (enable leading) or after it (enable lagging). The verdicts are accumulated, and the delay tap that positions the enable window is moved by one step only after enough evidence in the same direction has built up.

A second trigger, long-idle, starts a recovery pass for the case where a long time has gone by without any periodic refresh. That pass performs several back-to-back read and sample rounds inside a single busy window, so that it can apply more than one tap step. Because a pass has no upper bound on its length, the block counts cycles while it owns the interface and issues refresh commands itself whenever a refresh interval runs out. A build parameter removes the tracking function entirely. In that case busy never rises and the tap holds its initial setting.

Top module: `strobe_track_ctrl`

## Requirements
- R1: During and right after reset, busy, read request and refresh are low and the tap equals TAP_INIT.
- R2: An armed refresh-done puts busy high one cycle after it is sampled, well within the 10-cycle limit. A periodic pass makes one read request.
- R3: The read request is raised only while busy. An acknowledge is taken only while the request is high. Busy falls in the cycle after the acknowledge of the last round. An acknowledge seen while no request is pending changes nothing.
- R4: A trigger arms when its input is sampled low. Starting a pass disarms every trigger input that is high, so holding refresh-done or long-idle high after a pass starts no further pass.
- R5: On each taken sample, sample_lead_i = 1 (enable leading) adds one to a signed vote and 0 (enable lagging) subtracts one. When the vote reaches +THRESH the tap rises by one; when it reaches -THRESH the tap falls by one. In both cases the vote clears. The tap changes only on a taken sample.
- R6: The tap saturates at 0 and at TAP_MAX without wrapping. A threshold crossing at a limit clears the vote and leaves the tap unchanged.
- R7: An armed long-idle starts a pass of IDLE_ROUNDS read and sample rounds in one busy window, with a one-cycle gap between rounds. Long-idle wins when both triggers are armed together.
- R8: While busy, refresh_req_o pulses for one cycle every REFI_CYCLES cycles, counted from the rise of busy. The pulse is suppressed when it would fall on the edge that ends the pass.
- R9: With TRACK_EN = 0, busy, read request and refresh stay low and the tap holds TAP_INIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_refresh_done_i | input | 1 | Controller reports a completed periodic refresh |
| ctl_long_idle_i | input | 1 | Controller requests long-idle recovery |
| busy_o | output | 1 | Block owns the memory command interface |
| rd_req_o | output | 1 | Read burst request to the read engine |
| rd_ack_i | input | 1 | Read engine has a sample ready this cycle |
| sample_lead_i | input | 1 | Verdict with the acknowledge: 1 enable leads, 0 enable lags |
| refresh_req_o | output | 1 | One-cycle refresh command issued by the block |
| tap_o | output | TAP_W | Enable delay tap setting |

## Verification
The bench builds the block with a 3-bit tap (TAP_MAX 7, TAP_INIT 5), THRESH 3, IDLE_ROUNDS 4 and REFI_CYCLES 12. It also builds a second copy with TRACK_EN 0. With these small values both tap limits can be reached in a few dozen passes, so saturation at each end and the vote clearing at a limit are exercised. A slowed read engine stretches a long-idle pass across many refresh intervals, which covers the internal refresh pulses and the suppression of a pulse on the edge that ends the pass. The disabled copy shares every stimulus, so its outputs are held against the same traffic.

// File: rtl/stt_pkg.sv
// Shared types for the strobe gate drift tracking controller.
package stt_pkg;
    // Pass sequencer states: idle, read requested, one-cycle gap between rounds.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_GAP  = 2'd2
    } pass_state_e;
endpackage

// File: rtl/stt_pass_fsm.sv
// Pass sequencer: arms the two triggers, starts a periodic (one round) or
// long-idle (IDLE_ROUNDS rounds) pass, and drives busy and the read request.
// Assumes that the read engine holds rd_ack_i for one cycle per burst.
module stt_pass_fsm
    import stt_pkg::*;
#(
    parameter int IDLE_ROUNDS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic refresh_done_i,
    input  logic long_idle_i,
    input  logic rd_ack_i,
    output logic busy_o,
    output logic rd_req_o,
    output logic take_o,
    output logic finish_o
);
    localparam int RND_W = $clog2(IDLE_ROUNDS + 1);
    localparam logic [RND_W-1:0] RND_LONG = RND_W'(IDLE_ROUNDS);
    localparam logic [RND_W-1:0] RND_ONE  = RND_W'(1);

    pass_state_e      state_q;
    logic [RND_W-1:0] rounds_q;
    logic             arm_ref_q;
    logic             arm_idle_q;
    logic             start_long;
    logic             start_ref;
    logic             start_any;

    // Trigger decode: long-idle has priority over refresh-done.
    always_comb begin
        start_long = (state_q == ST_IDLE) && long_idle_i && arm_idle_q;
        start_ref  = (state_q == ST_IDLE) && !start_long && refresh_done_i && arm_ref_q;
        start_any  = start_long || start_ref;
        take_o     = (state_q == ST_REQ) && rd_ack_i;
        finish_o   = take_o && (rounds_q == RND_ONE);
        busy_o     = (state_q != ST_IDLE);
        rd_req_o   = (state_q == ST_REQ);
    end

    // Arm flags: set while the input is low, cleared by a start that saw it high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_ref_q  <= 1'b1;
            arm_idle_q <= 1'b1;
        end else begin
            if (start_any && refresh_done_i) arm_ref_q <= 1'b0;
            else if (!refresh_done_i)        arm_ref_q <= 1'b1;
            if (start_any && long_idle_i)    arm_idle_q <= 1'b0;
            else if (!long_idle_i)           arm_idle_q <= 1'b1;
        end
    end

    // State and round count update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            rounds_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_long) begin
                        state_q  <= ST_REQ;
                        rounds_q <= RND_LONG;
                    end else if (start_ref) begin
                        state_q  <= ST_REQ;
                        rounds_q <= RND_ONE;
                    end
                end
                ST_REQ: begin
                    if (finish_o) begin
                        state_q <= ST_IDLE;
                    end else if (take_o) begin
                        state_q  <= ST_GAP;
                        rounds_q <= rounds_q - RND_ONE;
                    end
                end
                ST_GAP:  state_q <= ST_REQ;
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/stt_vote_tap.sv
// Evidence accumulator and tap stepper: a signed vote moves by one per taken
// sample; reaching +/-THRESH steps the tap (saturating) and clears the vote.
// Assumes TAP_INIT <= TAP_MAX < 2**TAP_W and THRESH >= 1.
module stt_vote_tap #(
    parameter int TAP_W    = 6,
    parameter int TAP_MAX  = 63,
    parameter int TAP_INIT = 32,
    parameter int THRESH   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_i,
    input  logic             lead_i,
    output logic [TAP_W-1:0] tap_o
);
    localparam int VOTE_W = $clog2(THRESH + 1) + 1;
    localparam logic signed [VOTE_W-1:0] VOTE_HI  = VOTE_W'(THRESH - 1);
    localparam logic signed [VOTE_W-1:0] VOTE_LO  = -VOTE_HI;
    localparam logic signed [VOTE_W-1:0] VOTE_ONE = VOTE_W'(1);
    localparam logic [TAP_W-1:0]         TAP_TOP  = TAP_W'(TAP_MAX);
    localparam logic [TAP_W-1:0]         TAP_RST  = TAP_W'(TAP_INIT);
    localparam logic [TAP_W-1:0]         TAP_ONE  = TAP_W'(1);

    logic signed [VOTE_W-1:0] vote_q;
    logic [TAP_W-1:0]         tap_q;

    // Vote accumulation and saturating tap step on threshold crossing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vote_q <= '0;
            tap_q  <= TAP_RST;
        end else if (take_i) begin
            if (lead_i) begin
                if (vote_q == VOTE_HI) begin
                    vote_q <= '0;
                    if (tap_q != TAP_TOP) tap_q <= tap_q + TAP_ONE;
                end else begin
                    vote_q <= vote_q + VOTE_ONE;
                end
            end else begin
                if (vote_q == VOTE_LO) begin
                    vote_q <= '0;
                    if (tap_q != '0) tap_q <= tap_q - TAP_ONE;
                end else begin
                    vote_q <= vote_q - VOTE_ONE;
                end
            end
        end
    end

    assign tap_o = tap_q;
endmodule

// File: rtl/stt_refi_timer.sv
// Refresh interval timer: counts cycles while busy and emits a one-cycle
// refresh request every REFI_CYCLES cycles unless the pass ends on that edge.
// Assumes REFI_CYCLES >= 2.
module stt_refi_timer #(
    parameter int REFI_CYCLES = 780
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_i,
    input  logic finish_i,
    output logic refresh_o
);
    localparam int CNT_W = $clog2(REFI_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REFI_CYCLES - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             pulse_q;

    // Interval count and refresh pulse generation.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy_i) begin
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q   <= '0;
            pulse_q <= !finish_i;
        end else begin
            cnt_q   <= cnt_q + CNT_ONE;
            pulse_q <= 1'b0;
        end
    end

    assign refresh_o = pulse_q;
endmodule

// File: rtl/strobe_track_ctrl.sv
// Top of the strobe gate drift tracking controller. Joins the pass sequencer,
// vote/tap stepper and refresh timer; TRACK_EN = 0 ties all outputs to rest.
// Assumes the controller drops its trigger within 10 cycles of busy falling.
module strobe_track_ctrl #(
    parameter int TRACK_EN    = 1,
    parameter int TAP_W       = 6,
    parameter int TAP_MAX     = 63,
    parameter int TAP_INIT    = 32,
    parameter int THRESH      = 8,
    parameter int IDLE_ROUNDS = 16,
    parameter int REFI_CYCLES = 780
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_refresh_done_i,
    input  logic             ctl_long_idle_i,
    output logic             busy_o,
    output logic             rd_req_o,
    input  logic             rd_ack_i,
    input  logic             sample_lead_i,
    output logic             refresh_req_o,
    output logic [TAP_W-1:0] tap_o
);
    generate
        if (TRACK_EN != 0) begin : g_track
            logic take;
            logic finish;
            logic busy;

            stt_pass_fsm #(.IDLE_ROUNDS(IDLE_ROUNDS)) u_fsm (
                .clk            (clk),
                .rst_n          (rst_n),
                .refresh_done_i (ctl_refresh_done_i),
                .long_idle_i    (ctl_long_idle_i),
                .rd_ack_i       (rd_ack_i),
                .busy_o         (busy),
                .rd_req_o       (rd_req_o),
                .take_o         (take),
                .finish_o       (finish)
            );

            stt_vote_tap #(
                .TAP_W    (TAP_W),
                .TAP_MAX  (TAP_MAX),
                .TAP_INIT (TAP_INIT),
                .THRESH   (THRESH)
            ) u_vote (
                .clk    (clk),
                .rst_n  (rst_n),
                .take_i (take),
                .lead_i (sample_lead_i),
                .tap_o  (tap_o)
            );

            stt_refi_timer #(.REFI_CYCLES(REFI_CYCLES)) u_refi (
                .clk       (clk),
                .rst_n     (rst_n),
                .busy_i    (busy),
                .finish_i  (finish),
                .refresh_o (refresh_req_o)
            );

            assign busy_o = busy;
        end else begin : g_off
            assign busy_o        = 1'b0;
            assign rd_req_o      = 1'b0;
            assign refresh_req_o = 1'b0;
            assign tap_o         = TAP_W'(TAP_INIT);
        end
    endgenerate
endmodule

// File: rtl/strobe_track_ctrl_chk.sv
// Assertion checker bound to strobe_track_ctrl; observes ports only.
module strobe_track_ctrl_chk #(
    parameter int TRACK_EN = 1,
    parameter int TAP_W    = 6,
    parameter int TAP_MAX  = 63,
    parameter int TAP_INIT = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_refresh_done_i,
    input logic             ctl_long_idle_i,
    input logic             busy_o,
    input logic             rd_req_o,
    input logic             rd_ack_i,
    input logic             refresh_req_o,
    input logic [TAP_W-1:0] tap_o
);
    AST_BUSY_ON_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        ((TRACK_EN != 0) && !busy_o && ctl_refresh_done_i && !$past(ctl_refresh_done_i)) |=> busy_o); // R2
    AST_BUSY_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((TRACK_EN != 0) && !busy_o && ctl_long_idle_i && !$past(ctl_long_idle_i)) |=> busy_o); // R7
    AST_REQ_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> busy_o); // R3
    AST_BUSY_ENDS_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(rd_req_o && rd_ack_i)); // R3
    AST_TAP_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(tap_o) <= int'($past(tap_o)) + 1) && (int'(tap_o) + 1 >= int'($past(tap_o)))); // R5
    AST_TAP_MOVES_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_o != $past(tap_o)) |-> $past(rd_req_o && rd_ack_i)); // R5
    AST_TAP_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tap_o) <= TAP_MAX); // R6
    AST_REFRESH_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req_o |-> busy_o); // R8
    AST_REFRESH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req_o |=> !refresh_req_o); // R8
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (TRACK_EN != 0) || (!busy_o && !refresh_req_o && (tap_o == TAP_W'(TAP_INIT)))); // R9
endmodule

bind strobe_track_ctrl strobe_track_ctrl_chk #(
    .TRACK_EN (TRACK_EN),
    .TAP_W    (TAP_W),
    .TAP_MAX  (TAP_MAX),
    .TAP_INIT (TAP_INIT)
) u_chk (
    .clk                (clk),
    .rst_n              (rst_n),
    .ctl_refresh_done_i (ctl_refresh_done_i),
    .ctl_long_idle_i    (ctl_long_idle_i),
    .busy_o             (busy_o),
    .rd_req_o           (rd_req_o),
    .rd_ack_i           (rd_ack_i),
    .refresh_req_o      (refresh_req_o),
    .tap_o              (tap_o)
);

// File: tb/strobe_track_ctrl_tb_top.sv
`timescale 1ns / 100ps
module strobe_track_ctrl_tb_top;
    localparam int P_TAP_W  = 3;
    localparam int P_TAP_MAX = 7;
    localparam int P_TAP_INIT = 5;
    localparam int P_THRESH = 3;
    localparam int P_ROUNDS = 4;
    localparam int P_REFI   = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_done = 1'b0;
    logic long_idle = 1'b0;
    logic rd_ack = 1'b0;
    logic sample_lead = 1'b0;
    logic busy_o, rd_req_o, refresh_req_o;
    logic [P_TAP_W-1:0] tap_o;
    logic busy_off, rd_req_off, refresh_off;
    logic [P_TAP_W-1:0] tap_off;

    always #2.5 clk = ~clk;

    strobe_track_ctrl #(
        .TRACK_EN(1), .TAP_W(P_TAP_W), .TAP_MAX(P_TAP_MAX), .TAP_INIT(P_TAP_INIT),
        .THRESH(P_THRESH), .IDLE_ROUNDS(P_ROUNDS), .REFI_CYCLES(P_REFI)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_refresh_done_i(ref_done), .ctl_long_idle_i(long_idle),
        .busy_o(busy_o), .rd_req_o(rd_req_o), .rd_ack_i(rd_ack), .sample_lead_i(sample_lead),
        .refresh_req_o(refresh_req_o), .tap_o(tap_o)
    );

    strobe_track_ctrl #(
        .TRACK_EN(0), .TAP_W(P_TAP_W), .TAP_MAX(P_TAP_MAX), .TAP_INIT(P_TAP_INIT),
        .THRESH(P_THRESH), .IDLE_ROUNDS(P_ROUNDS), .REFI_CYCLES(P_REFI)
    ) dut_off (
        .clk(clk), .rst_n(rst_n), .ctl_refresh_done_i(ref_done), .ctl_long_idle_i(long_idle),
        .busy_o(busy_off), .rd_req_o(rd_req_off), .rd_ack_i(rd_ack), .sample_lead_i(sample_lead),
        .refresh_req_o(refresh_off), .tap_o(tap_off)
    );

    int  errors = 0;
    int  checks = 0;
    bit  finished = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural reference: pass progress, vote, tap and refresh interval.
    int m_state = 0;   // 0 idle, 1 requesting, 2 gap
    int m_rounds = 0;
    int m_vote = 0;
    int m_tap = P_TAP_INIT;
    int m_cnt = 0;
    bit m_pulse = 0;
    bit m_arm_r = 1;
    bit m_arm_i = 1;

    always @(posedge clk) begin
        bit take, fin, st_l, st_r;
        if (!rst_n) begin
            m_state = 0; m_rounds = 0; m_vote = 0; m_tap = P_TAP_INIT;
            m_cnt = 0; m_pulse = 0; m_arm_r = 1; m_arm_i = 1;
        end else begin
            take = (m_state == 1) && rd_ack;
            fin  = take && (m_rounds == 1);
            st_l = (m_state == 0) && long_idle && m_arm_i;
            st_r = (m_state == 0) && !st_l && ref_done && m_arm_r;
            if (m_state == 0) begin m_cnt = 0; m_pulse = 0; end
            else if (m_cnt == P_REFI - 1) begin m_cnt = 0; m_pulse = !fin; end
            else begin m_cnt++; m_pulse = 0; end
            if (take) begin
                m_vote += sample_lead ? 1 : -1;
                if (m_vote == P_THRESH) begin m_vote = 0; if (m_tap < P_TAP_MAX) m_tap++; end
                if (m_vote == -P_THRESH) begin m_vote = 0; if (m_tap > 0) m_tap--; end
            end
            if ((st_l || st_r) && ref_done) m_arm_r = 0; else if (!ref_done) m_arm_r = 1;
            if ((st_l || st_r) && long_idle) m_arm_i = 0; else if (!long_idle) m_arm_i = 1;
            case (m_state)
                0: if (st_l) begin m_state = 1; m_rounds = P_ROUNDS; end
                   else if (st_r) begin m_state = 1; m_rounds = 1; end
                1: if (fin) m_state = 0;
                   else if (take) begin m_rounds--; m_state = 2; end
                default: m_state = 1;
            endcase
        end
    end

    // Per-cycle comparison against the reference, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(busy_o == (m_state != 0), "R2 busy vs model", busy_o, m_state != 0);
            check(rd_req_o == (m_state == 1), "R3 rd_req vs model", rd_req_o, m_state == 1);
            check(refresh_req_o == m_pulse, "R8 refresh vs model", refresh_req_o, m_pulse);
            check(int'(tap_o) == m_tap, "R5 tap vs model", tap_o, m_tap);
            check(!busy_off && !rd_req_off && !refresh_off && int'(tap_off) == P_TAP_INIT,
                  "R9 disabled copy quiet", tap_off, P_TAP_INIT);
        end
    end

    // Read engine model: answers a request after ack_gap cycles with a queued verdict.
    int ack_gap = 0;
    int wait_cnt = 0;
    int acks_seen = 0;
    bit stray = 0;
    bit stray_lead = 0;
    bit dflt_lead = 1;
    bit lead_q[$];

    always @(negedge clk) begin
        if (rd_req_o && !rd_ack) begin
            if (wait_cnt <= 0) begin
                rd_ack <= 1'b1;
                if (lead_q.size() > 0) sample_lead <= lead_q.pop_front();
                else sample_lead <= dflt_lead;
                acks_seen++;
                wait_cnt = ack_gap;
            end else begin
                wait_cnt--;
                rd_ack <= 1'b0;
            end
        end else begin
            rd_ack <= stray;
            if (stray) sample_lead <= stray_lead;
        end
    end

    // Busy length and refresh pulse monitor.
    int busy_len = 0;
    int pulses = 0;
    always @(negedge clk) begin
        if (busy_o) busy_len++;
        if (refresh_req_o) pulses++;
    end

    task automatic run_trigger(input bit use_long, input bit use_ref, output int lat, output int nacks);
        int a0;
        @(negedge clk);
        if (use_long) long_idle = 1'b1;
        if (use_ref) ref_done = 1'b1;
        a0 = acks_seen;
        lat = 0;
        do begin @(negedge clk); lat++; end while (!busy_o && lat < 20);
        while (busy_o) @(negedge clk);
        nacks = acks_seen - a0;
        repeat (3) begin
            @(negedge clk);
            check(!busy_o, "R4 no restart while trigger held", busy_o, 0);
        end
        long_idle = 1'b0;
        ref_done = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic periodic(input bit lead, input int n);
        int lat, na;
        for (int i = 0; i < n; i++) begin
            lead_q.push_back(lead);
            run_trigger(1'b0, 1'b1, lat, na);
            check(lat >= 1 && lat < 10, "R2 busy latency", lat, 1);
            check(na == 1, "R2 one read per periodic pass", na, 1);
        end
    endtask

    initial begin
        int lat, na;
        repeat (5) @(negedge clk);
        check(!busy_o && !rd_req_o && !refresh_req_o, "R1 outputs low in reset", busy_o, 0);
        check(int'(tap_o) == P_TAP_INIT, "R1 tap in reset", tap_o, P_TAP_INIT);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !rd_req_o, "R1 idle after reset", busy_o, 0);
        check(int'(tap_o) == P_TAP_INIT, "R1 tap after reset", tap_o, P_TAP_INIT);

        periodic(1'b1, 2);
        check(int'(tap_o) == P_TAP_INIT, "R5 no step below threshold", tap_o, P_TAP_INIT);
        periodic(1'b1, 1);
        check(int'(tap_o) == P_TAP_INIT + 1, "R5 step up at +THRESH", tap_o, P_TAP_INIT + 1);
        periodic(1'b1, 6);
        check(int'(tap_o) == P_TAP_MAX, "R6 saturate at TAP_MAX", tap_o, P_TAP_MAX);
        periodic(1'b0, 3);
        check(int'(tap_o) == P_TAP_MAX - 1, "R5 step down at -THRESH", tap_o, P_TAP_MAX - 1);
        periodic(1'b0, 3 * P_TAP_MAX);
        check(int'(tap_o) == 0, "R6 saturate at zero", tap_o, 0);

        // Long-idle: four leads give one step and leave vote +1.
        repeat (4) lead_q.push_back(1'b1);
        run_trigger(1'b1, 1'b0, lat, na);
        check(lat >= 1 && lat < 10, "R7 busy latency on long-idle", lat, 1);
        check(na == P_ROUNDS, "R7 rounds in long-idle pass", na, P_ROUNDS);
        check(int'(tap_o) == 1, "R7 tap after long-idle pass", tap_o, 1);

        // Both triggers together: long-idle wins; four lags give one step down.
        repeat (4) lead_q.push_back(1'b0);
        run_trigger(1'b1, 1'b1, lat, na);
        check(na == P_ROUNDS, "R7 long-idle priority", na, P_ROUNDS);
        check(int'(tap_o) == 0, "R7 tap after priority pass", tap_o, 0);

        // Slow engine stretches a long-idle pass across many refresh intervals.
        ack_gap = 30;
        wait_cnt = 30;
        busy_len = 0;
        pulses = 0;
        repeat (2) lead_q.push_back(1'b1);
        repeat (2) lead_q.push_back(1'b0);
        run_trigger(1'b1, 1'b0, lat, na);
        check(pulses == (busy_len - 1) / P_REFI, "R8 refresh pulse count", pulses, (busy_len - 1) / P_REFI);
        check(pulses >= 2, "R8 refreshes issued in long pass", pulses, 2);
        ack_gap = 0;
        wait_cnt = 0;

        // Stray acknowledges while idle must not move vote or tap.
        stray_lead = 1'b1;
        stray = 1'b1;
        repeat (10) @(negedge clk);
        stray = 1'b0;
        repeat (2) @(negedge clk);
        check(!busy_o, "R3 stray ack starts nothing", busy_o, 0);
        check(int'(tap_o) == 0, "R3 stray ack leaves tap", tap_o, 0);
        periodic(1'b1, 2);
        check(int'(tap_o) == 0, "R3 vote untouched by stray acks", tap_o, 0);
        periodic(1'b1, 1);
        check(int'(tap_o) == 1, "R5 step after clean votes", tap_o, 1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R3 watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule